// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a 128-word by 16-bit serially accessed EEPROM for use inside a chip or a system model. A host drives a chip select, a serial clock and a serial data line. The block returns a serial data output with a separate output-enable, so the line can float. All three inputs are oversampled by the block's own system clock. Each rising edge of the serial clock then moves one bit into the command logic.

A frame opens with a start bit, which is the first 1 seen on the data line while chip select is high. A 2-bit opcode and an 8-bit address field follow. Read, single-word write and single-word erase take their address from the low seven bits of that field. With opcode 00, the top two address-field bits select one of four extended commands. These are write enable, write disable, write-all and chip erase. Reads run without a fixed length and step to the next word after every 16 bits. Write-type commands start a busy counter with a parameter-set length. That counter stands in for the nonvolatile programming time, and the host can poll it on the data output.

Top module: `eep_3w_slave`

## Requirements
- R1: After reset every word holds 0xFFFF, writes are locked, and the data output is not enabled.
- R2: While chip select is high and no frame is open, 0 bits on the data line are skipped. The first 1 opens a frame.
- R3: Opcode 10 is a read. After the last address bit the output is enabled and drives a 0. Each following serial-clock rising edge then puts out the next word bit, most significant bit first.
- R4: A read that continues past bit 0 of a word moves on to the next address. Address 127 is followed by address 0.
- R5: Opcode 01 with the lock released stores the 16 data bits that follow the address, sent most significant bit first, into the addressed word.
- R6: With opcode 00, address-field top bits 11 release the lock and 00 set it. The other six bits are ignored. While the lock is set, write, write-all, erase and chip erase change no word and start no busy period.
- R7: Opcode 11 with the lock released sets the addressed word to 0xFFFF and leaves every other word unchanged.
- R8: With opcode 00, top bits 01 write the 16 data bits that follow into every word. Top bits 10 set every word to 0xFFFF. Both need the lock released.
- R9: After an executed write-type command, raising chip select with no frame open drives 0 while the busy period runs and 1 after BUSY_CYCLES system clocks. Start bits are not accepted during the busy period.
- R10: While chip select is low the output is not enabled. Dropping chip select abandons any unfinished frame without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock; data is taken on its rising edge |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out (read bits or ready/busy status) |
| do_en_o | output | 1 | Output enable for do_o; low means the line floats |

## Verification
The block registers a serial-clock rising edge once and then detects it. Each edge therefore takes effect two system clocks after the bench raises the clock. The read output changes on that same system-clock edge, so the bench holds the serial clock high for four system clocks and low for two more before it samples the output. That places every sample well past the update. Status is read three system clocks after chip select rises, which covers the one-cycle input register and the registered enable. The ready level is checked BUSY_CYCLES plus four clocks after the write pulse, so the busy counter has run out by then.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DAT,
    ST_RD,
    ST_DONE
  } eep_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_WRALL  = 2'b01;
  localparam logic [1:0] EXT_ERALL  = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;
endpackage

// File: rtl/eep_sync.sv
module eep_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic rise_o,
  output logic di_o
);
  logic sk_q, sk_qq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o  <= 1'b0;
      sk_q  <= 1'b0;
      sk_qq <= 1'b0;
      di_o  <= 1'b0;
    end else begin
      cs_o  <= cs_i;
      sk_q  <= sk_i;
      sk_qq <= sk_q;
      di_o  <= di_i;
    end
  end

  assign rise_o = sk_q & ~sk_qq;
endmodule

// File: rtl/eep_busy.sv
module eep_busy #(
  parameter int unsigned BUSY_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned BW = $clog2(BUSY_CYCLES + 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= BW'(BUSY_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - BW'(1);
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R9
  AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - BW'(1))); // R9
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr1_i,
  input  logic          wrall_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem[g] <= '1;
      else if (wrall_i || (wr1_i && wr_addr_i == AW'(g)))
        mem[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  AST_ONE_WRITE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr1_i, wrall_i})); // R8
endmodule

// File: rtl/eep_cmd.sv
module eep_cmd
  import eep_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rise_i,
  input  logic          di_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr1_o,
  output logic          wrall_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          do_o,
  output logic          do_en_o
);
  localparam int unsigned FW  = AW + 3;
  localparam int unsigned MX  = (FW > DW) ? FW : DW;
  localparam int unsigned SW  = MX - 1;
  localparam int unsigned CW  = $clog2(MX);
  localparam int unsigned DCW = $clog2(DW);

  eep_state_e    st_q;
  logic [SW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [DCW-1:0] rd_bit_q;
  logic          wr_en_q, stat_q, all_q;

  logic [FW-1:0] field;
  logic [DW-1:0] dword;
  logic [1:0]    op, ext;
  logic [AW-1:0] addr;

  always_comb begin
    field = {sh_q[FW-2:0], di_i};
    dword = {sh_q[DW-2:0], di_i};
    op    = field[FW-1:FW-2];
    ext   = field[AW:AW-1];
    addr  = field[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      rd_bit_q  <= '0;
      rd_addr_o <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr1_o     <= 1'b0;
      wrall_o   <= 1'b0;
      wr_en_q   <= 1'b0;
      stat_q    <= 1'b0;
      all_q     <= 1'b0;
      do_o      <= 1'b0;
      do_en_o   <= 1'b0;
    end else begin
      wr1_o   <= 1'b0;
      wrall_o <= 1'b0;
      if (!cs_i) begin
        st_q    <= ST_IDLE;
        cnt_q   <= '0;
        do_en_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            do_en_o <= stat_q;
            do_o    <= ~busy_i;
            if (rise_i && di_i && !busy_i) begin
              st_q    <= ST_CMD;
              cnt_q   <= '0;
              stat_q  <= 1'b0;
              do_en_o <= 1'b0;
            end
          end
          ST_CMD: if (rise_i) begin
            sh_q <= {sh_q[SW-2:0], di_i};
            if (cnt_q != CW'(FW - 1)) begin
              cnt_q <= cnt_q + CW'(1);
            end else begin
              cnt_q <= '0;
              st_q  <= ST_DONE;
              unique case (op)
                OP_READ: begin
                  st_q      <= ST_RD;
                  rd_addr_o <= addr;
                  rd_bit_q  <= DCW'(DW - 1);
                  do_o      <= 1'b0;
                  do_en_o   <= 1'b1;
                end
                OP_WRITE: begin
                  st_q      <= ST_DAT;
                  all_q     <= 1'b0;
                  wr_addr_o <= addr;
                end
                OP_ERASE: if (wr_en_q) begin
                  wr1_o     <= 1'b1;
                  wr_addr_o <= addr;
                  wr_data_o <= '1;
                  stat_q    <= 1'b1;
                end
                default: begin
                  unique case (ext)
                    EXT_UNLOCK: wr_en_q <= 1'b1;
                    EXT_LOCK:   wr_en_q <= 1'b0;
                    EXT_WRALL: begin
                      st_q  <= ST_DAT;
                      all_q <= 1'b1;
                    end
                    default: if (wr_en_q) begin
                      wrall_o   <= 1'b1;
                      wr_data_o <= '1;
                      stat_q    <= 1'b1;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DAT: if (rise_i) begin
            sh_q <= {sh_q[SW-2:0], di_i};
            if (cnt_q != CW'(DW - 1)) begin
              cnt_q <= cnt_q + CW'(1);
            end else begin
              cnt_q <= '0;
              st_q  <= ST_DONE;
              if (wr_en_q) begin
                wr1_o     <= ~all_q;
                wrall_o   <= all_q;
                wr_data_o <= dword;
                stat_q    <= 1'b1;
              end
            end
          end
          ST_RD: if (rise_i) begin
            do_o <= rd_data_i[rd_bit_q];
            if (rd_bit_q == '0) begin
              rd_bit_q  <= DCW'(DW - 1);
              rd_addr_o <= rd_addr_o + AW'(1);
            end else begin
              rd_bit_q <= rd_bit_q - DCW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_FLOAT_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !do_en_o); // R10
  AST_LOCKED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr1_o || wrall_o) |-> wr_en_q); // R6
  AST_READ_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD && cs_i && rise_i && rd_bit_q == '0 && rd_addr_o == '1)
      |=> rd_addr_o == '0); // R4
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && busy_i) |=> st_q == ST_IDLE); // R9
endmodule

// File: rtl/eep_3w_slave.sv
module eep_3w_slave #(
  parameter int unsigned DW          = 16,
  parameter int unsigned AW          = 7,
  parameter int unsigned BUSY_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_en_o
);
  logic          cs_s, rise_s, di_s, busy;
  logic          wr1, wrall;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;

  eep_sync u_sync (
    .clk_i, .rst_ni, .cs_i, .sk_i, .di_i,
    .cs_o(cs_s), .rise_o(rise_s), .di_o(di_s)
  );

  eep_cmd #(.DW(DW), .AW(AW)) u_cmd (
    .clk_i, .rst_ni,
    .cs_i(cs_s), .rise_i(rise_s), .di_i(di_s), .busy_i(busy),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr1_o(wr1), .wrall_o(wrall), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .do_o, .do_en_o
  );

  eep_array #(.DW(DW), .AW(AW)) u_array (
    .clk_i, .rst_ni,
    .wr1_i(wr1), .wrall_i(wrall), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  eep_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i, .rst_ni, .start_i(wr1 | wrall), .busy_o(busy)
  );
endmodule

// File: tb/eep_3w_slave_tb_top.sv
`timescale 1ns/1ps
module eep_3w_slave_tb_top;
  localparam int BUSY = 120;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w, do_en;
  int total = 0, bad = 0;
  logic [15:0] exp_mem [128];
  bit en_model = 1'b0;

  always #2.5 clk = ~clk;

  eep_3w_slave #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_en_o(do_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); di = b;
    clks(2); sk = 1'b1;
    clks(4); sk = 1'b0;
    clks(2);
  endtask

  task automatic cs_on();
    @(negedge clk); cs = 1'b1; clks(2);
  endtask

  task automatic cs_off();
    @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0; clks(4);
  endtask

  task automatic head(input int zeros, input logic [1:0] op, input logic [7:0] fld);
    for (int i = 0; i < zeros; i++) bit_out(1'b0);
    bit_out(1'b1);
    bit_out(op[1]); bit_out(op[0]);
    for (int i = 7; i >= 0; i--) bit_out(fld[i]);
  endtask

  // status poll after a write-type frame; expect busy then ready if executed
  task automatic status(input bit executed);
    cs_on(); clks(3);
    if (executed) begin
      chk(do_en === 1'b1 && do_w === 1'b0, "R9 busy", {do_en, do_w}, 2'b10);
      clks(BUSY + 4);
      chk(do_en === 1'b1 && do_w === 1'b1, "R9 ready", {do_en, do_w}, 2'b11);
    end else begin
      chk(do_en === 1'b0, "R6 no status when locked", do_en, 0);
    end
    cs_off();
  endtask

  task automatic rd(input int a, input int n, input int zeros, input string tag);
    logic [15:0] word;
    cs_on();
    head(zeros, 2'b10, {1'b0, 7'(a)});
    chk(do_en === 1'b1 && do_w === 1'b0, "R3 dummy zero", {do_en, do_w}, 2'b10);
    for (int w = 0; w < n; w++) begin
      for (int b = 15; b >= 0; b--) begin
        bit_out(1'b0);
        word[b] = do_w;
      end
      chk(word === exp_mem[(a + w) % 128], tag, word, exp_mem[(a + w) % 128]);
    end
    cs_off();
    chk(do_en === 1'b0, "R10 float on cs low", do_en, 0);
  endtask

  task automatic wr(input int a, input logic [15:0] d, input bit chk_stat);
    cs_on();
    head(0, 2'b01, {1'b0, 7'(a)});
    for (int i = 15; i >= 0; i--) bit_out(d[i]);
    cs_off();
    if (en_model) exp_mem[a] = d;
    if (chk_stat) status(en_model);
    else if (en_model) clks(BUSY + 4);
  endtask

  task automatic ext(input logic [1:0] sel, input logic [5:0] rest);
    cs_on(); head(0, 2'b00, {sel, rest}); cs_off();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) exp_mem[i] = 16'hFFFF;
    clks(4); rst_n = 1'b1; clks(2);
    chk(do_en === 1'b0, "R1 output disabled after reset", do_en, 0);

    rd(0, 2, 0, "R1 reset content");

    wr(5, 16'h1234, 1'b1);
    rd(5, 1, 0, "R6 locked write ignored");

    ext(2'b11, 6'b101010); en_model = 1'b1;
    wr(5, 16'h1234, 1'b1);
    rd(5, 1, 0, "R5 single write");
    rd(5, 1, 3, "R2 zeros before start");

    for (int a = 0; a < 128; a++) wr(a, 16'(a * 16'h0101) ^ 16'h5A3C, a < 2);
    rd(0, 128, 0, "R5 sweep");
    rd(125, 5, 0, "R4 wrap");

    cs_on(); head(0, 2'b11, 8'd7); cs_off();
    exp_mem[7] = 16'hFFFF;
    status(1'b1);
    rd(6, 3, 0, "R7 erase one word");

    cs_on(); head(0, 2'b01, 8'd9);
    for (int i = 0; i < 8; i++) bit_out(1'b1);
    cs_off();
    cs_on(); clks(3);
    chk(do_en === 1'b0, "R10 aborted frame no status", do_en, 0);
    cs_off();
    rd(9, 1, 0, "R10 aborted write");

    ext(2'b00, 6'b110011); en_model = 1'b0;
    wr(10, 16'h0BAD, 1'b1);
    rd(10, 1, 0, "R6 write after lock");
    cs_on(); head(0, 2'b11, 8'd11); cs_off();
    status(1'b0);
    rd(11, 1, 0, "R6 erase after lock");

    ext(2'b11, 6'b000000); en_model = 1'b1;
    cs_on(); head(0, 2'b00, 8'b0100_0000);
    for (int i = 15; i >= 0; i--) bit_out(16'hA5C3 >> i);
    cs_off();
    for (int i = 0; i < 128; i++) exp_mem[i] = 16'hA5C3;
    status(1'b1);
    rd(60, 4, 0, "R8 write-all");
    rd(127, 2, 0, "R8 write-all wrap");

    ext(2'b10, 6'b000000);
    for (int i = 0; i < 128; i++) exp_mem[i] = 16'hFFFF;
    status(1'b1);
    rd(30, 3, 0, "R8 chip erase");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule